// File: doc/BRIEF.md
# Host-to-Controller Command Mailbox

This block is a small register file that lets a host processor hand commands to an embedded management controller and collect the answers. The host sees a memory-mapped window: a command word, a status word, two pointer words, a four-word outbound data buffer and a four-word inbound data buffer. Writing the command word while the mailbox is idle latches the command, marks the mailbox busy and sends a one-cycle doorbell pulse to the controller.

The controller sees the latched command, both pointers and the outbound words. Only the words covered by the byte length in the command are shown to it. It finishes a command with a one-cycle completion strobe that carries an error flag, an 8-bit error code and four reply words. The mailbox then clears busy and records the outcome. If the command asked for it, the mailbox also raises a pending-interrupt bit, which the host clears by writing a one to it.

Top module: `hc_mailbox`

## Requirements
- R1: After reset, the status, command, pointer and both buffer windows read zero, and the interrupt, doorbell and ready outputs are low.
- R2: A host write to offset 0x00 while idle latches the full word onto `fw_cmd`. One cycle later `fw_doorbell` pulses high for exactly one cycle. Status busy (bit 0) reads 1, and the error bit and code are cleared.
- R3: A write to offset 0x00 while busy is dropped: `fw_cmd` keeps its value and no doorbell is produced.
- R4: Offset 0x08 holds the source pointer and offset 0x0C the destination pointer, both driven on `fw_src_ptr`/`fw_dst_ptr`. The outbound buffer is four words at 0x80, 0x84, 0x88 and 0x8C. All of these read back what was written.
- R5: A completion strobe while busy clears busy and copies the error flag into status bit 1. Status bits 23:16 take the controller's code when the flag is set and zero otherwise. A completion strobe while idle changes nothing.
- R6: Status bit 2, the pending interrupt, is set on completion only if command bit 8 was set in the latched command. `host_irq` always equals that bit.
- R7: Writing offset 0x04 with bit 2 set clears the pending interrupt, and writing it with bit 2 clear leaves it alone. A completion that sets the bit in the same cycle takes priority over the clear.
- R8: On a completion without error, the inbound buffer (0x90, 0x94, 0x98, 0x9C) captures the four reply words. On a completion with error, it is cleared to zero.
- R9: The outbound word i reaches `fw_wdata` only when i < ceil(L/4), where L is command bits 23:16. Other words show zero, so L=0 shows none and L>=13 shows all four.
- R10: A read returns its data on `h_rdata`, with `h_ready` high, one cycle after the sampling edge. Offsets outside the mapped set read zero.
- R11: Every code value passes into status bits 23:16 unchanged. This includes the named codes 1 unsupported, 2 not serviced, 3 unable to service, 4 invalid, 5 failed, 6 and 7 security failures.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_addr | input | ADDR_W | Host byte offset |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe |
| h_wdata | input | DATA_W | Host write data |
| h_rdata | output | DATA_W | Host read data, one cycle after the read |
| h_ready | output | 1 | Access accepted, one cycle after the strobe |
| host_irq | output | 1 | Completion interrupt (pending bit) |
| fw_doorbell | output | 1 | One-cycle new-command pulse |
| fw_cmd | output | DATA_W | Latched command word |
| fw_src_ptr | output | DATA_W | Source pointer |
| fw_dst_ptr | output | DATA_W | Destination pointer |
| fw_wdata | output | BUF_WORDS*DATA_W | Outbound words, masked by length, word 0 in the low bits |
| fw_done | input | 1 | Completion strobe |
| fw_err | input | 1 | Completion error flag |
| fw_code | input | 8 | Completion error code |
| fw_rdata | input | BUF_WORDS*DATA_W | Reply words, word 0 in the low bits |

## Verification
The doorbell, busy, `fw_cmd` and the masked `fw_wdata` change on the clock edge that samples a command write. The bench therefore checks them at the falling edge right after that write, and checks the doorbell again one cycle later to see it drop. Status, interrupt and inbound buffer take their new values on the edge that samples the completion strobe, so the bench reads them only after that edge. Each host read is answered one cycle after its sampling edge: the driver queues the expected word when it raises the read strobe, and the monitor pops the queue at the following falling edge, where it also requires `h_ready`.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

   // command word fields
   localparam int unsigned MB_CMD_IRQ_BIT  = 8;
   localparam int unsigned MB_CMD_SUB_LSB  = 12;
   localparam int unsigned MB_CMD_LEN_LSB  = 16;
   localparam int unsigned MB_LEN_W        = 8;

   // status word fields
   localparam int unsigned MB_STS_BUSY     = 0;
   localparam int unsigned MB_STS_ERR      = 1;
   localparam int unsigned MB_STS_IRQ      = 2;
   localparam int unsigned MB_STS_CODE_LSB = 16;
   localparam int unsigned MB_CODE_W       = 8;

   // byte offsets
   localparam int unsigned MB_OFF_CMD  = 'h00;
   localparam int unsigned MB_OFF_STS  = 'h04;
   localparam int unsigned MB_OFF_SRC  = 'h08;
   localparam int unsigned MB_OFF_DST  = 'h0C;
   localparam int unsigned MB_WIN_OUT  = 'h8;   // offset bits [7:4] of outbound window
   localparam int unsigned MB_WIN_IN   = 'h9;   // offset bits [7:4] of inbound window

   typedef enum logic [MB_CODE_W-1:0] {
      MB_OK             = 8'd0,
      MB_UNSUPPORTED    = 8'd1,
      MB_NOT_SERVICED   = 8'd2,
      MB_CANNOT_SERVICE = 8'd3,
      MB_BAD_CMD        = 8'd4,
      MB_FAILED         = 8'd5,
      MB_SEC_REJECT_A   = 8'd6,
      MB_SEC_REJECT_B   = 8'd7
   } mb_code_e;

   function automatic logic [31:0] mb_pack_status(input logic busy_i,
                                                  input logic err_i,
                                                  input logic irq_i,
                                                  input logic [MB_CODE_W-1:0] code_i);
      logic [31:0] s;
      s = '0;
      s[MB_STS_BUSY] = busy_i;
      s[MB_STS_ERR]  = err_i;
      s[MB_STS_IRQ]  = irq_i;
      s[MB_STS_CODE_LSB +: MB_CODE_W] = code_i;
      return s;
   endfunction

endpackage

// File: rtl/mbox_core.sv
module mbox_core
   import mbox_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cmd_we,
   input  logic [DATA_W-1:0]    wdata,
   input  logic                 irq_clr,
   input  logic                 src_we,
   input  logic                 dst_we,
   input  logic                 done,
   input  logic                 err_in,
   input  logic [MB_CODE_W-1:0] code_in,
   output logic                 busy,
   output logic                 err,
   output logic                 irq,
   output logic [MB_CODE_W-1:0] code,
   output logic                 doorbell,
   output logic [DATA_W-1:0]    cmd,
   output logic [DATA_W-1:0]    src_ptr,
   output logic [DATA_W-1:0]    dst_ptr
);

   logic accept;
   logic finish;

   assign accept = cmd_we && !busy;
   assign finish = done && busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         err      <= 1'b0;
         code     <= '0;
         doorbell <= 1'b0;
         cmd      <= '0;
      end else begin
         doorbell <= accept;
         if (accept) begin
            cmd  <= wdata;
            busy <= 1'b1;
            err  <= 1'b0;
            code <= '0;
         end else if (finish) begin
            busy <= 1'b0;
            err  <= err_in;
            code <= err_in ? code_in : '0;
         end
      end
   end

   // set on a requested completion wins over a host clear in the same cycle
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq <= 1'b0;
      end else if (finish && cmd[MB_CMD_IRQ_BIT]) begin
         irq <= 1'b1;
      end else if (irq_clr) begin
         irq <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         src_ptr <= '0;
         dst_ptr <= '0;
      end else begin
         if (src_we) src_ptr <= wdata;
         if (dst_we) dst_ptr <= wdata;
      end
   end

endmodule

// File: rtl/mbox_wbuf.sv
module mbox_wbuf
   import mbox_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int WORDS  = 4,
   parameter int IDX_W  = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    we,
   input  logic [IDX_W-1:0]        idx,
   input  logic [DATA_W-1:0]       wdata,
   input  logic [MB_LEN_W-1:0]     len,
   output logic [WORDS*DATA_W-1:0] host_words,
   output logic [WORDS*DATA_W-1:0] fw_words
);

   localparam int CW = MB_LEN_W + 1;

   logic [CW-1:0] len_ext;
   logic [CW-1:0] used;

   assign len_ext = {1'b0, len};
   assign used    = (len_ext + CW'(3)) >> 2;

   for (genvar i = 0; i < WORDS; i++) begin : g_word
      logic [DATA_W-1:0] word_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            word_q <= '0;
         end else if (we && idx == IDX_W'(i)) begin
            word_q <= wdata;
         end
      end

      assign host_words[i*DATA_W +: DATA_W] = word_q;
      assign fw_words[i*DATA_W +: DATA_W]   = (CW'(i) < used) ? word_q : '0;
   end

endmodule

// File: rtl/mbox_rbuf.sv
module mbox_rbuf #(
   parameter int DATA_W = 32,
   parameter int WORDS  = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    capture,
   input  logic                    wipe,
   input  logic [WORDS*DATA_W-1:0] reply,
   output logic [WORDS*DATA_W-1:0] words
);

   for (genvar i = 0; i < WORDS; i++) begin : g_word
      logic [DATA_W-1:0] word_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            word_q <= '0;
         end else if (capture) begin
            word_q <= wipe ? '0 : reply[i*DATA_W +: DATA_W];
         end
      end

      assign words[i*DATA_W +: DATA_W] = word_q;
   end

endmodule

// File: rtl/hc_mailbox.sv
module hc_mailbox
   import mbox_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32,
   parameter int BUF_WORDS = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [ADDR_W-1:0]           h_addr,
   input  logic                        h_wr,
   input  logic                        h_rd,
   input  logic [DATA_W-1:0]           h_wdata,
   output logic [DATA_W-1:0]           h_rdata,
   output logic                        h_ready,
   output logic                        host_irq,
   output logic                        fw_doorbell,
   output logic [DATA_W-1:0]           fw_cmd,
   output logic [DATA_W-1:0]           fw_src_ptr,
   output logic [DATA_W-1:0]           fw_dst_ptr,
   output logic [BUF_WORDS*DATA_W-1:0] fw_wdata,
   input  logic                        fw_done,
   input  logic                        fw_err,
   input  logic [MB_CODE_W-1:0]        fw_code,
   input  logic [BUF_WORDS*DATA_W-1:0] fw_rdata
);

   localparam int BUF_W  = BUF_WORDS * DATA_W;
   localparam int IDX_W  = (BUF_WORDS > 1) ? $clog2(BUF_WORDS) : 1;
   localparam logic [2:0] WORDS_L = 3'(BUF_WORDS);

   if (DATA_W != 32) begin : g_bad_data_w
      $error("hc_mailbox: DATA_W must be 32");
   end
   if (ADDR_W < 8) begin : g_bad_addr_w
      $error("hc_mailbox: ADDR_W must be at least 8");
   end
   if (BUF_WORDS < 1 || BUF_WORDS > 4) begin : g_bad_words
      $error("hc_mailbox: BUF_WORDS must be 1 to 4");
   end

   // ---------------- address decode ----------------
   logic             sel_cmd, sel_sts, sel_src, sel_dst, sel_out, sel_in;
   logic [IDX_W-1:0] widx;
   logic             word_ok;

   assign word_ok = ({1'b0, h_addr[3:2]} < WORDS_L);
   assign widx    = IDX_W'(h_addr[3:2]);
   assign sel_cmd = (h_addr == ADDR_W'(MB_OFF_CMD));
   assign sel_sts = (h_addr == ADDR_W'(MB_OFF_STS));
   assign sel_src = (h_addr == ADDR_W'(MB_OFF_SRC));
   assign sel_dst = (h_addr == ADDR_W'(MB_OFF_DST));
   assign sel_out = (h_addr[ADDR_W-1:4] == (ADDR_W-4)'(MB_WIN_OUT)) && word_ok;
   assign sel_in  = (h_addr[ADDR_W-1:4] == (ADDR_W-4)'(MB_WIN_IN))  && word_ok;

   // ---------------- command / status core ----------------
   logic                 busy, err, irq;
   logic [MB_CODE_W-1:0] code;

   mbox_core #(.DATA_W(DATA_W)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_we   (h_wr && sel_cmd),
      .wdata    (h_wdata),
      .irq_clr  (h_wr && sel_sts && h_wdata[MB_STS_IRQ]),
      .src_we   (h_wr && sel_src),
      .dst_we   (h_wr && sel_dst),
      .done     (fw_done),
      .err_in   (fw_err),
      .code_in  (fw_code),
      .busy     (busy),
      .err      (err),
      .irq      (irq),
      .code     (code),
      .doorbell (fw_doorbell),
      .cmd      (fw_cmd),
      .src_ptr  (fw_src_ptr),
      .dst_ptr  (fw_dst_ptr)
   );

   assign host_irq = irq;

   // ---------------- data buffers ----------------
   logic [BUF_W-1:0] out_words;
   logic [BUF_W-1:0] rd_words;

   mbox_wbuf #(.DATA_W(DATA_W), .WORDS(BUF_WORDS), .IDX_W(IDX_W)) u_wbuf (
      .clk        (clk),
      .rst_n      (rst_n),
      .we         (h_wr && sel_out),
      .idx        (widx),
      .wdata      (h_wdata),
      .len        (fw_cmd[MB_CMD_LEN_LSB +: MB_LEN_W]),
      .host_words (out_words),
      .fw_words   (fw_wdata)
   );

   mbox_rbuf #(.DATA_W(DATA_W), .WORDS(BUF_WORDS)) u_rbuf (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (busy && fw_done),
      .wipe    (fw_err),
      .reply   (fw_rdata),
      .words   (rd_words)
   );

   // ---------------- host read port ----------------
   logic [DATA_W-1:0] rd_mux;

   always_comb begin
      rd_mux = '0;
      if (sel_cmd)      rd_mux = fw_cmd;
      else if (sel_sts) rd_mux = mb_pack_status(busy, err, irq, code);
      else if (sel_src) rd_mux = fw_src_ptr;
      else if (sel_dst) rd_mux = fw_dst_ptr;
      else if (sel_out) rd_mux = out_words[widx*DATA_W +: DATA_W];
      else if (sel_in)  rd_mux = rd_words[widx*DATA_W +: DATA_W];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         h_rdata <= '0;
         h_ready <= 1'b0;
      end else begin
         h_ready <= h_wr || h_rd;
         h_rdata <= h_rd ? rd_mux : '0;
      end
   end

endmodule

// File: rtl/mbox_checker.sv
module mbox_checker #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter int BUF_W  = 128
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] h_addr,
   input logic              h_wr,
   input logic              h_rd,
   input logic [DATA_W-1:0] h_wdata,
   input logic              h_ready,
   input logic              host_irq,
   input logic              fw_doorbell,
   input logic [DATA_W-1:0] fw_cmd,
   input logic              fw_done,
   input logic              fw_err,
   input logic              busy,
   input logic [BUF_W-1:0]  rd_words
);

   a_r2_idle_cmd_rings: assert property (@(posedge clk) disable iff (!rst_n)
      (h_wr && h_addr == '0 && !busy) |=> (fw_doorbell && busy && fw_cmd == $past(h_wdata)));

   a_r3_busy_cmd_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (h_wr && h_addr == '0 && busy) |=> (!fw_doorbell && $stable(fw_cmd)));

   a_r2_bell_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      fw_doorbell |=> !fw_doorbell);

   a_r5_done_clears_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && fw_done) |=> !busy);

   a_r6_irq_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(host_irq) |-> $past(fw_cmd[8] && busy && fw_done));

   a_r7_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (h_wr && h_addr == ADDR_W'(4) && h_wdata[2] && !(busy && fw_done && fw_cmd[8]))
      |=> !host_irq);

   a_r8_error_wipes_reply: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && fw_done && fw_err) |=> (rd_words == '0));

   a_r10_ready_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (h_wr || h_rd) |=> h_ready);

endmodule

bind hc_mailbox mbox_checker #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .BUF_W  (BUF_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .h_addr      (h_addr),
   .h_wr        (h_wr),
   .h_rd        (h_rd),
   .h_wdata     (h_wdata),
   .h_ready     (h_ready),
   .host_irq    (host_irq),
   .fw_doorbell (fw_doorbell),
   .fw_cmd      (fw_cmd),
   .fw_done     (fw_done),
   .fw_err      (fw_err),
   .busy        (busy),
   .rd_words    (rd_words)
);

// File: tb/tb_hc_mailbox.sv
module tb_hc_mailbox;
   import mbox_pkg::*;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [7:0]   h_addr = '0;
   logic         h_wr = 1'b0;
   logic         h_rd = 1'b0;
   logic [31:0]  h_wdata = '0;
   logic [31:0]  h_rdata;
   logic         h_ready;
   logic         host_irq;
   logic         fw_doorbell;
   logic [31:0]  fw_cmd, fw_src_ptr, fw_dst_ptr;
   logic [127:0] fw_wdata;
   logic         fw_done = 1'b0;
   logic         fw_err = 1'b0;
   logic [7:0]   fw_code = '0;
   logic [127:0] fw_rdata = '0;

   int n_chk = 0;
   int n_err = 0;
   bit done_run = 0;

   logic [31:0] exp_q[$];
   string       tag_q[$];
   logic        rd_seen;

   always #10 clk = ~clk;

   hc_mailbox dut (
      .clk(clk), .rst_n(rst_n), .h_addr(h_addr), .h_wr(h_wr), .h_rd(h_rd),
      .h_wdata(h_wdata), .h_rdata(h_rdata), .h_ready(h_ready), .host_irq(host_irq),
      .fw_doorbell(fw_doorbell), .fw_cmd(fw_cmd), .fw_src_ptr(fw_src_ptr),
      .fw_dst_ptr(fw_dst_ptr), .fw_wdata(fw_wdata), .fw_done(fw_done),
      .fw_err(fw_err), .fw_code(fw_code), .fw_rdata(fw_rdata)
   );

   task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: the read answered one cycle after its sampling edge
   always @(posedge clk) rd_seen <= rst_n && h_rd;

   always @(negedge clk) begin : monitor
      logic [31:0] e;
      string t;
      if (rd_seen === 1'b1) begin
         if (exp_q.size() == 0) begin
            n_chk++; n_err++;
            $display("FAIL R10 unexpected read data actual=%h expected=none", h_rdata);
         end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check({t, " ready"}, {127'd0, h_ready}, 128'd1);
            check(t, {96'd0, h_rdata}, {96'd0, e});
         end
      end
   end

   // driver tasks, entered at a falling edge
   task automatic host_write(input logic [7:0] a, input logic [31:0] d);
      h_addr = a; h_wdata = d; h_wr = 1'b1;
      @(negedge clk);
      h_wr = 1'b0;
   endtask

   task automatic host_read(input logic [7:0] a, input logic [31:0] e, input string tag);
      h_addr = a; h_rd = 1'b1;
      exp_q.push_back(e);
      tag_q.push_back(tag);
      @(negedge clk);
      h_rd = 1'b0;
   endtask

   task automatic fw_finish(input logic er, input logic [7:0] c, input logic [127:0] r);
      fw_done = 1'b1; fw_err = er; fw_code = c; fw_rdata = r;
      @(negedge clk);
      fw_done = 1'b0; fw_err = 1'b0;
   endtask

   task automatic drain;
      repeat (2) @(negedge clk);
   endtask

   task automatic summary;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done_run) begin
         n_chk++; n_err++;
         $display("FAIL watchdog run did not complete actual=hung expected=done");
         summary();
      end
   end

   localparam logic [31:0] W0 = 32'hA1A1_0001, W1 = 32'hB2B2_0002,
                           W2 = 32'hC3C3_0003, W3 = 32'hD4D4_0004;
   localparam logic [127:0] REPLY = 128'h4444_0004_3333_0003_2222_0002_1111_0001;

   initial begin : stim
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 irq", {127'd0, host_irq}, 128'd0);
      check("R1 doorbell", {127'd0, fw_doorbell}, 128'd0);
      check("R1 ready", {127'd0, h_ready}, 128'd0);
      rst_n = 1'b1;
      @(negedge clk);
      host_read(8'h04, 32'h0, "R1 status");
      host_read(8'h00, 32'h0, "R1 command");
      host_read(8'h80, 32'h0, "R1 outbound");
      host_read(8'h9C, 32'h0, "R1 inbound");
      drain();

      // R4 pointers and outbound buffer
      host_write(8'h08, 32'h1000_2000);
      host_write(8'h0C, 32'h3000_4000);
      check("R4 src port", {96'd0, fw_src_ptr}, {96'd0, 32'h1000_2000});
      check("R4 dst port", {96'd0, fw_dst_ptr}, {96'd0, 32'h3000_4000});
      host_write(8'h80, W0);
      host_write(8'h84, W1);
      host_write(8'h88, W2);
      host_write(8'h8C, W3);
      host_read(8'h08, 32'h1000_2000, "R4 src readback");
      host_read(8'h0C, 32'h3000_4000, "R4 dst readback");
      host_read(8'h84, W1, "R4 out word1");
      host_read(8'h8C, W3, "R4 out word3");
      drain();

      // R2 command with irq request, length 5 -> two words (R9)
      host_write(8'h00, 32'h0005_3121);
      check("R2 doorbell high", {127'd0, fw_doorbell}, 128'd1);
      check("R2 fw_cmd", {96'd0, fw_cmd}, {96'd0, 32'h0005_3121});
      check("R9 len5 two words", fw_wdata, {32'h0, 32'h0, W1, W0});
      @(negedge clk);
      check("R2 doorbell one cycle", {127'd0, fw_doorbell}, 128'd0);
      host_read(8'h04, 32'h0000_0001, "R2 busy status");

      // R3 command while busy dropped
      host_write(8'h00, 32'h0000_0077);
      check("R3 no doorbell", {127'd0, fw_doorbell}, 128'd0);
      check("R3 cmd kept", {96'd0, fw_cmd}, {96'd0, 32'h0005_3121});
      drain();

      // R5/R6/R8 successful completion
      fw_finish(1'b0, 8'h00, REPLY);
      check("R6 irq raised", {127'd0, host_irq}, 128'd1);
      host_read(8'h04, 32'h0000_0004, "R5 status ok");
      host_read(8'h90, 32'h1111_0001, "R8 in word0");
      host_read(8'h94, 32'h2222_0002, "R8 in word1");
      host_read(8'h98, 32'h3333_0003, "R8 in word2");
      host_read(8'h9C, 32'h4444_0004, "R8 in word3");
      drain();

      // R7 write-one-to-clear
      host_write(8'h04, 32'hFFFF_FFFB);
      check("R7 zero write keeps irq", {127'd0, host_irq}, 128'd1);
      host_write(8'h04, 32'h0000_0004);
      check("R7 w1c clears irq", {127'd0, host_irq}, 128'd0);
      host_read(8'h04, 32'h0, "R7 status after clear");
      drain();

      // R9 length 16 all words, no irq request; R5 error path; R8 wipe
      host_write(8'h00, 32'h0010_0042);
      check("R9 len16 all words", fw_wdata, {W3, W2, W1, W0});
      fw_finish(1'b1, MB_SEC_REJECT_A, ~REPLY);
      check("R6 no irq without request", {127'd0, host_irq}, 128'd0);
      host_read(8'h04, 32'h0006_0002, "R5 status error");
      host_read(8'h90, 32'h0, "R8 wiped word0");
      host_read(8'h9C, 32'h0, "R8 wiped word3");
      drain();

      // R9 length 0 and 13
      host_write(8'h00, 32'h0000_0001);
      check("R9 len0 no words", fw_wdata, 128'd0);
      fw_finish(1'b0, 8'h00, REPLY);
      host_write(8'h00, 32'h000D_0001);
      check("R9 len13 all words", fw_wdata, {W3, W2, W1, W0});
      fw_finish(1'b0, 8'h00, REPLY);
      drain();

      // R11 every named code carried
      for (int c = 1; c < 8; c++) begin
         host_write(8'h00, 32'h0000_0100 | c);
         fw_finish(1'b1, 8'(c), REPLY);
         host_read(8'h04, (32'(c) << 16) | 32'h6, $sformatf("R11 code %0d", c));
         drain();
         host_write(8'h04, 32'h4);
      end
      host_write(8'h00, 32'h0000_0100);
      fw_finish(1'b1, 8'hA5, REPLY);
      host_read(8'h04, 32'h00A5_0006, "R11 arbitrary code");
      drain();
      host_write(8'h04, 32'h4);

      // R5 completion while idle ignored
      fw_finish(1'b0, 8'h33, REPLY);
      host_read(8'h04, 32'h00A5_0002, "R5 idle done ignored");
      host_read(8'h90, 32'h0, "R5 idle done keeps inbound");
      drain();

      // R7 set beats clear in the same cycle
      host_write(8'h00, 32'h0000_0100);
      fw_finish(1'b0, 8'h00, REPLY);
      host_write(8'h00, 32'h0000_0100);
      h_addr = 8'h04; h_wdata = 32'h4; h_wr = 1'b1;
      fw_done = 1'b1; fw_err = 1'b0;
      @(negedge clk);
      h_wr = 1'b0; fw_done = 1'b0;
      check("R7 set wins over clear", {127'd0, host_irq}, 128'd1);
      host_read(8'h04, 32'h0000_0004, "R7 status after collision");

      // R10 unmapped offsets
      host_read(8'h40, 32'h0, "R10 unmapped 0x40");
      host_read(8'hA0, 32'h0, "R10 unmapped 0xA0");
      host_read(8'h10, 32'h0, "R10 unmapped 0x10");
      drain();

      if (exp_q.size() != 0) begin
         n_chk++; n_err++;
         $display("FAIL R10 reads left unanswered actual=%0d expected=0", exp_q.size());
      end
      done_run = 1;
      summary();
   end

endmodule